// File: doc/BRIEF.md
# XOR-Index Bit Permuter with Extension

This unit rearranges the bits of a 64-bit operand in one clocked step. Every result bit comes from the source bit at the index given by the destination index XOR a 6-bit control value. That single rule covers many swaps. It reverses bits inside a byte, exchanges nibbles, swaps bytes inside halfwords, and reverses bytes inside 32-bit or 64-bit lanes. No separate swap opcode is needed for any of them.

After the permutation, a 2-bit width code selects the low 8, 16, 32 or 64 bits of the permuted value. For widths below 64, the bits above the selected width are filled from its top bit (signed) or cleared (unsigned). The unit therefore turns a loaded big-endian field into a sign- or zero-extended native value in one operation. The result and its valid flag are registered.

Top module: `xperm_unit`

## Requirements
- R1: Before extension, permuted bit i equals operand bit (i XOR ctrl) for every i in 0..63, where ctrl is the 6-bit control input.
- R2: ctrl = 0 with width code 3 returns the operand unchanged.
- R3: ctrl = 0x01 exchanges each adjacent bit pair, ctrl = 0x04 exchanges adjacent nibbles, and ctrl = 0x08 swaps the two bytes of every halfword.
- R4: ctrl = 0x18 reverses byte order inside each 32-bit word. ctrl = 0x07 reverses bit order inside each byte and leaves the bytes in place.
- R5: Width code 0 keeps 8 bits, 1 keeps 16, 2 keeps 32 and 3 keeps 64. With the signed flag high and a width below 64, the bits above the width copy the width's top permuted bit.
- R6: With the signed flag low and a width below 64, the bits above the width are zero.
- R7: Width code 3 passes the permuted value unchanged whatever the signed flag is.
- R8: ctrl = 0x18, width code 2 and the signed flag high give the sign-extended 32-bit byte reversal of the low word in a single operation.
- R9: res_vld rises exactly one cycle after in_vld is sampled high and is low otherwise. res_data updates only on a cycle with in_vld high. Reset clears res_vld to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operation request |
| in_data | input | 64 | Operand |
| in_ctrl | input | 6 | XOR permutation control |
| in_width | input | 2 | Extension width code (0:8, 1:16, 2:32, 3:64) |
| in_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| res_vld | output | 1 | Result valid |
| res_data | output | 64 | Registered result |

## Verification
The hardest case to reach is the one where the bit that drives the extension comes from far away, so an error in the index mapping shows up only as wrong fill bits. This happens when a high control bit carries the width's top bit in from the upper half of the operand. The stimulus sweeps all 64 control values against every width and both fill modes. It uses random operands and single-bit operands, so each source bit in turn lands on the sign position. Gaps in in_vld check that the result holds between operations.

// File: rtl/xperm_pkg.sv
package xperm_pkg;
  localparam int unsigned XW   = 64;
  localparam int unsigned CW   = $clog2(XW);
  localparam int unsigned SZW  = 2;

  typedef logic [XW-1:0]  word_t;
  typedef logic [CW-1:0]  ctrl_t;
  typedef logic [SZW-1:0] width_t;

  // number of kept bits for a width code: 8 << code
  function automatic int unsigned width_bits(input width_t w);
    return 32'd8 << w;
  endfunction

  // mask of the kept low bits
  function automatic word_t keep_mask(input width_t w);
    word_t m;
    for (int i = 0; i < XW; i++) m[i] = (i < int'(width_bits(w)));
    return m;
  endfunction
endpackage

// File: rtl/xperm_net.sv
module xperm_net
  import xperm_pkg::*;
(
  input  word_t src,
  input  ctrl_t ctrl,
  output word_t dst
);
  for (genvar i = 0; i < XW; i++) begin : g_bit
    localparam ctrl_t IDX = ctrl_t'(i);
    assign dst[i] = src[IDX ^ ctrl];
  end
endmodule

// File: rtl/xperm_ext.sv
module xperm_ext
  import xperm_pkg::*;
(
  input  word_t  perm,
  input  width_t width,
  input  logic   sgn,
  output word_t  ext_out,
  output logic   fill_bit
);
  word_t mask;
  logic  top;

  always_comb begin
    mask = keep_mask(width);
    top  = 1'b0;
    for (int k = 0; k < (1 << SZW); k++)
      if (width == width_t'(k)) top = perm[width_bits(width_t'(k)) - 1];
    fill_bit = sgn & top;
    ext_out  = (perm & mask) | ({XW{fill_bit}} & ~mask);
  end
endmodule

// File: rtl/xperm_unit.sv
module xperm_unit
  import xperm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [63:0] in_data,
  input  logic [5:0]  in_ctrl,
  input  logic [1:0]  in_width,
  input  logic        in_signed,
  output logic        res_vld,
  output logic [63:0] res_data
);
  word_t perm_w;
  word_t ext_w;
  logic  fill_w;

  xperm_net u_net (.src(in_data), .ctrl(in_ctrl), .dst(perm_w));
  xperm_ext u_ext (.perm(perm_w), .width(in_width), .sgn(in_signed),
                   .ext_out(ext_w), .fill_bit(fill_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_data <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res_data <= ext_w;
    end
  end

  // R1: permuted bit 0 reads the source at index ctrl
  a_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    perm_w[0] == in_data[in_ctrl]);

  p_ctrl0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_ctrl == 6'd0 && in_width == 2'd3) |=> res_data == $past(in_data));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_signed && in_width == 2'd0) |=> res_data[63:8] == 56'd0);

  p_pass64_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_width == 2'd3) |=> res_data == $past(perm_w));

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_signed && in_width == 2'd2) |=> res_data[63:32] == {32{res_data[31]}});

  p_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(in_vld));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res_data));
endmodule

// File: tb/xperm_unit_test.sv
module xperm_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_vld = 0;
  logic [63:0] in_data = '0;
  logic [5:0]  in_ctrl = '0;
  logic [1:0]  in_width = '0;
  logic        in_signed = 0;
  logic        res_vld;
  logic [63:0] res_data;
  int tests = 0, fails = 0;
  bit done = 0;

  xperm_unit uut (.*);

  always #10 clk = ~clk;

  function automatic logic [63:0] ref_perm(logic [63:0] d, logic [5:0] c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = d[(i ^ c) & 63];
    return r;
  endfunction

  function automatic logic [63:0] ref_full(logic [63:0] d, logic [5:0] c,
                                           logic [1:0] w, logic s);
    logic [63:0] p = ref_perm(d, c);
    int n = 8 * (1 << w);
    logic f = s && (n < 64) && p[n-1];
    for (int i = n; i < 64; i++) p[i] = f;
    return p;
  endfunction

  function automatic logic [63:0] bswap32(logic [63:0] d);
    logic [63:0] r;
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 4; b++)
        r[w*32 + b*8 +: 8] = d[w*32 + (3-b)*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one operation; result sampled on the falling edge after capture
  task automatic op(logic [63:0] d, logic [5:0] c, logic [1:0] w, logic s,
                    string req, logic [63:0] exp);
    @(negedge clk);
    in_vld = 1; in_data = d; in_ctrl = c; in_width = w; in_signed = s;
    @(negedge clk);
    in_vld = 0;
    chk(req, res_data, exp);
    chk("R9 vld", {63'd0, res_vld}, 64'd1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, e, held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R9 reset vld", {63'd0, res_vld}, 64'd0);
    rst_n = 1;
    a = 64'h0123_4567_89ab_cdef;
    op(a, 6'h00, 2'd3, 1, "R2", a);
    op(64'h5555_5555_5555_5555, 6'h01, 2'd3, 0, "R3 bitpair", 64'haaaa_aaaa_aaaa_aaaa);
    op(a, 6'h04, 2'd3, 0, "R3 nibble", 64'h1032_5476_98ba_dcfe);
    op(a, 6'h08, 2'd3, 0, "R3 byte16", 64'h2301_6745_ab89_efcd);
    op(a, 6'h18, 2'd3, 0, "R4 bswap32", bswap32(a));
    op(64'h0000_0000_0000_0001, 6'h07, 2'd3, 0, "R4 bitrev", 64'h80);
    op(64'h0000_0000_0000_0080, 6'h00, 2'd0, 1, "R5 s8", 64'hffff_ffff_ffff_ff80);
    op(64'h0000_0000_0000_8000, 6'h00, 2'd1, 1, "R5 s16", 64'hffff_ffff_ffff_8000);
    op(64'hffff_ffff_ffff_ff80, 6'h00, 2'd0, 0, "R6 z8", 64'h80);
    op(64'hffff_ffff_8000_0000, 6'h00, 2'd2, 0, "R6 z32", 64'h8000_0000);
    op(64'h8000_0000_0000_0000, 6'h00, 2'd3, 1, "R7 s64", 64'h8000_0000_0000_0000);
    op(64'h8000_0000_0000_0000, 6'h3f, 2'd3, 0, "R7 rev", 64'h1);
    op(64'h0000_0000_0000_0080, 6'h18, 2'd2, 1, "R8", 64'hffff_ffff_8000_0000);
    op(64'h0000_0000_1234_5678, 6'h18, 2'd2, 1, "R8 pos", 64'h7856_3412);
    // hold check: idle cycles keep result, vld drops
    held = res_data;
    @(negedge clk); in_data = ~in_data;
    @(negedge clk);
    chk("R9 hold", res_data, held);
    chk("R9 idle vld", {63'd0, res_vld}, 64'd0);
    // sweep all controls, widths, modes
    for (int c = 0; c < 64; c++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 2; s++) begin
          a = {$urandom, $urandom};
          e = ref_full(a, 6'(c), 2'(w), 1'(s));
          op(a, 6'(c), 2'(w), 1'(s), (w == 3) ? "R1 sweep" : "R5 sweep", e);
        end
    // one-hot operands move each source bit onto sign positions
    for (int b = 0; b < 64; b++) begin
      int c = $urandom_range(0, 63);
      int w = $urandom_range(0, 2);
      a = 64'd1 << b;
      op(a, 6'(c), 2'(w), 1, "R5 onehot", ref_full(a, 6'(c), 2'(w), 1));
      op(a, 6'(c), 2'(w), 0, "R6 onehot", ref_full(a, 6'(c), 2'(w), 0));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule